// File: doc/BRIEF.md
# Synchronous Two-Wire Card Link Front End

This block is the card-side receiver and transmitter of a link made of a clock driven by the reader and one shared, open-drain data wire. The wire is modelled as a pull-up plus an output enable: when `lineOe` is high the card pulls the line low, otherwise the card lets it float high. All link activity is sampled by a fast system clock. The reader's clock, the data line and the card reset each pass through a synchronizer, and edges are found on the synchronized copies.

The reader frames a command with a start condition and a stop condition. The block shifts in exactly 24 bits, least significant bit first, and hands the word to the command logic. It also flags any frame whose length is wrong. After a good frame the command logic picks one of two replies. In the first it streams a given number of bytes out. The bytes are fetched one at a time through a request/valid handshake and sent LSB first. In the second it holds the line low, as a busy signal, until a done input arrives. A card reset pulse, applied while the reader clock is low, aborts whatever is running. When the pulse ends, the four-byte answer-to-reset is sent out through the same output path.

Top module: `cardLinkFront`

## Requirements
- R1: A start condition is a falling data line while the reader clock stays high. It opens a new frame and discards any bits already collected, also in the middle of a frame. A stop condition (rising data line while the reader clock is high) outside a frame has no effect.
- R2: Once a frame of exactly 24 bits is closed by a stop, `cmdValid` pulses for one system clock. `cmdWord` then carries the first received bit in bit 0, so bits [7:0] are the control byte, [15:8] the address byte and [23:16] the data byte.
- R3: The card changes the line level only after a falling reader-clock edge, or when a card reset aborts. The line is released while idle and while a frame is being received.
- R4: A stop that closes a frame of any length other than 24 bits pulses `frameErr` instead of `cmdValid`. The line is then pulled low from the first falling clock edge after the stop. It is released on the eighth falling edge, whatever `procDone` does.
- R5: Start and stop conditions have no effect during the answer-to-reset, during outgoing data and during a processing phase.
- R6: When the reply is a processing phase (`replyOut` low at the stop), the line goes low on the first falling edge after the stop. It is released on the first falling edge after `procDone` has pulsed, counted once the line is already low. Later clocks leave it high.
- R7: When the reply is outgoing data (`replyOut` high at the stop), `replyBytes` bytes are sent LSB first. Bit 0 of the first byte appears after the first falling edge following the stop. Each later falling edge presents the next bit. The falling edge after the last bit releases the line, and later clocks leave it high.
- R8: Each byte sent is obtained by one `byteReq` pulse answered by `byteValid` with `byteData`. The first request goes out when the reply starts. Every further request goes out as soon as the previous byte enters the shift register.
- R9: A card reset that is high while the reader clock is low releases the line at once and aborts any frame, output or processing phase. A card reset that is high only while the reader clock is high is ignored.
- R10: When the card reset ends, four bytes are fetched with `atrFetch` high and sent LSB first, one bit per falling clock edge. The first bit appears after the first falling edge. The line is released on the 33rd falling edge.
- R11: A data bit is sampled on a rising clock edge and counted only on the following falling edge. The rising edge that precedes a stop condition therefore adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Oversampling system clock |
| sysRstN | input | 1 | Active-low asynchronous system reset |
| cardClk | input | 1 | Reader clock, asynchronous |
| cardRst | input | 1 | Card reset from the reader, active high, asynchronous |
| lineIn | input | 1 | Level observed on the shared data wire |
| lineOe | output | 1 | High pulls the data wire low |
| cmdValid | output | 1 | One-cycle pulse: a 24-bit command was received |
| cmdWord | output | 24 | Received command, first bit in bit 0 |
| frameErr | output | 1 | One-cycle pulse: a frame had the wrong length |
| replyOut | input | 1 | Sampled at the stop: 1 selects outgoing data, 0 selects processing |
| replyBytes | input | 9 | Sampled at the stop: number of bytes to send |
| procDone | input | 1 | Pulse ending a processing phase |
| byteReq | output | 1 | One-cycle request for the next outgoing byte |
| atrFetch | output | 1 | High while the requested bytes belong to the answer-to-reset |
| byteValid | input | 1 | Marks `byteData` as the answer to a request |
| byteData | input | 8 | Byte to be sent |

## Verification
The bench fires start and stop glitches in the middle of outgoing data and of busy phases. A design that honours them would drop into a receive state and stop driving the line part way through a byte. It sends frames of 23 and 25 bits and restarted frames, and it puts the stop right after a rising clock edge. A receiver that counts on the rising edge would report 25 bits, and one that does not clear on a restart would keep stale bits. It pulses `procDone` before the line has gone low and times the release against exact falling edges. It also raises the card reset once while the clock is high and once while it is low, which catches an abort that ignores the clock level or a release that lands one edge early or late.

// File: rtl/cardLinkPkg.sv
package cardLinkPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_OUT,
    ST_PROC,
    ST_BAD,
    ST_HOLD
  } linkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rxClr;
    logic rxSample;
    logic rxCommit;
    logic txLoad;
    logic txShift;
    logic bufClr;
  } dpCtl_t;

endpackage

// File: rtl/linkSync.sv
module linkSync #(
  parameter int STAGES = 2
) (
  input  logic sysClk,
  input  logic sysRstN,
  input  logic cardClk,
  input  logic cardRst,
  input  logic lineIn,
  output logic clkRise,
  output logic clkFall,
  output logic clkHigh,
  output logic lineLevel,
  output logic startEv,
  output logic stopEv,
  output logic rstHigh
);
  localparam int NUM_IN = 3;
  localparam logic [NUM_IN-1:0] REST_VAL = 3'b010; // {rst, line, clk}

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] synced;
  logic [1:0]        prevQ;

  assign rawIn = {cardRst, lineIn, cardClk};

  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : gSync
      logic [STAGES-1:0] chain;
      always_ff @(posedge sysClk or negedge sysRstN) begin
        if (!sysRstN) chain <= {STAGES{REST_VAL[g]}};
        else          chain <= {chain[STAGES-2:0], rawIn[g]};
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) prevQ <= REST_VAL[1:0];
    else          prevQ <= synced[1:0];
  end

  assign clkHigh   = synced[0];
  assign lineLevel = synced[1];
  assign rstHigh   = synced[2];
  assign clkRise   = synced[0] & ~prevQ[0];
  assign clkFall   = ~synced[0] & prevQ[0];
  assign startEv   = synced[0] & prevQ[0] & prevQ[1] & ~synced[1];
  assign stopEv    = synced[0] & prevQ[0] & ~prevQ[1] & synced[1];

endmodule

// File: rtl/linkDatapath.sv
module linkDatapath
  import cardLinkPkg::*;
#(
  parameter int CMD_BITS = 24,
  parameter int BYTE_W   = 8,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic                lineLevel,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData,
  output logic [CMD_BITS-1:0] rxWord,
  output logic [CNT_W-1:0]    rxCount,
  output logic                txBit,
  output logic                txByteDone,
  output logic                bufValid
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(CMD_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic              pend;
  logic              pendBit;
  logic [BYTE_W-1:0] txReg;
  logic [IDX_W-1:0]  txIdx;
  logic [BYTE_W-1:0] bufReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord   <= '0;
      rxCount  <= '0;
      pend     <= 1'b0;
      pendBit  <= 1'b0;
      txReg    <= '1;
      txIdx    <= '0;
      bufReg   <= '0;
      bufValid <= 1'b0;
    end else begin
      // receive: sample on rise, count on the following fall
      if (ctl.rxClr) begin
        rxWord  <= '0;
        rxCount <= '0;
        pend    <= 1'b0;
      end else if (ctl.rxSample) begin
        pend    <= 1'b1;
        pendBit <= lineLevel;
      end else if (ctl.rxCommit && pend) begin
        rxWord <= {pendBit, rxWord[CMD_BITS-1:1]};
        if (rxCount != SAT_CNT) rxCount <= rxCount + CNT_W'(1);
        pend <= 1'b0;
      end
      // transmit shifter, LSB first
      if (ctl.txLoad) begin
        txReg <= bufReg;
        txIdx <= '0;
      end else if (ctl.txShift) begin
        txReg <= {1'b1, txReg[BYTE_W-1:1]};
        txIdx <= txIdx + IDX_W'(1);
      end
      // single-entry prefetch buffer
      if (byteValid) begin
        bufReg   <= byteData;
        bufValid <= 1'b1;
      end else if (ctl.txLoad || ctl.bufClr) begin
        bufValid <= 1'b0;
      end
    end
  end

  assign txBit      = txReg[0];
  assign txByteDone = (txIdx == LAST_IDX);

  // R8: a byte is moved into the shifter only after it was delivered
  assert_load_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txLoad |-> bufValid);

endmodule

// File: rtl/linkControl.sv
module linkControl
  import cardLinkPkg::*;
#(
  parameter int CMD_BITS  = 24,
  parameter int LEN_W     = 9,
  parameter int CNT_W     = 5,
  parameter int ATR_BYTES = 4,
  parameter int BAD_FALLS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkRise,
  input  logic             clkFall,
  input  logic             clkHigh,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic             rstHigh,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             txBit,
  input  logic             txByteDone,
  input  logic             replyOut,
  input  logic [LEN_W-1:0] replyBytes,
  input  logic             procDone,
  output dpCtl_t           ctl,
  output logic             cmdValid,
  output logic             frameErr,
  output logic             byteReq,
  output logic             atrFetch,
  output logic             lineOe
);
  localparam int FALL_W = $clog2(BAD_FALLS + 1);
  localparam logic [FALL_W-1:0] LAST_FALL = FALL_W'(BAD_FALLS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(CMD_BITS);

  linkState_e        state, stateN;
  logic [LEN_W-1:0]  bytesLeft, bytesLeftN;
  logic [FALL_W-1:0] fallCnt, fallCntN;
  logic outActive, outActiveN;
  logic lowYet, lowYetN;
  logic doneSeen, doneSeenN;
  logic atrMode, atrModeN;
  logic cmdValidN, frameErrN, byteReqN;
  logic abortEv;

  assign abortEv = rstHigh & ~clkHigh;

  always_comb begin
    stateN     = state;
    bytesLeftN = bytesLeft;
    fallCntN   = fallCnt;
    outActiveN = outActive;
    lowYetN    = lowYet;
    doneSeenN  = doneSeen;
    atrModeN   = atrMode;
    cmdValidN  = 1'b0;
    frameErrN  = 1'b0;
    byteReqN   = 1'b0;
    ctl        = '0;
    if (abortEv) begin
      stateN     = ST_HOLD;
      outActiveN = 1'b0;
      lowYetN    = 1'b0;
      doneSeenN  = 1'b0;
      atrModeN   = 1'b0;
      ctl.rxClr  = 1'b1;
      ctl.bufClr = 1'b1;
    end else begin
      case (state)
        ST_HOLD: begin
          if (!rstHigh) begin
            stateN     = ST_OUT;
            bytesLeftN = LEN_W'(ATR_BYTES);
            atrModeN   = 1'b1;
            outActiveN = 1'b0;
            byteReqN   = 1'b1;
          end
        end
        ST_IDLE: begin
          if (startEv) begin
            stateN    = ST_RX;
            ctl.rxClr = 1'b1;
          end
        end
        ST_RX: begin
          if (startEv) begin
            ctl.rxClr = 1'b1;
          end else if (stopEv) begin
            if (rxCount == FULL_CNT) begin
              cmdValidN = 1'b1;
              if (replyOut) begin
                stateN     = ST_OUT;
                bytesLeftN = replyBytes;
                atrModeN   = 1'b0;
                outActiveN = 1'b0;
                byteReqN   = (replyBytes != '0);
              end else begin
                stateN    = ST_PROC;
                lowYetN   = 1'b0;
                doneSeenN = 1'b0;
              end
            end else begin
              frameErrN = 1'b1;
              stateN    = ST_BAD;
              fallCntN  = '0;
              lowYetN   = 1'b0;
            end
          end else if (clkRise) begin
            ctl.rxSample = 1'b1;
          end else if (clkFall) begin
            ctl.rxCommit = 1'b1;
          end
        end
        ST_OUT: begin
          if (clkFall) begin
            if ((!outActive || txByteDone) && (bytesLeft != '0)) begin
              ctl.txLoad = 1'b1;
              outActiveN = 1'b1;
              bytesLeftN = bytesLeft - LEN_W'(1);
              byteReqN   = (bytesLeft > LEN_W'(1));
            end else if (outActive && !txByteDone) begin
              ctl.txShift = 1'b1;
            end else begin
              stateN     = ST_IDLE;
              outActiveN = 1'b0;
              atrModeN   = 1'b0;
            end
          end
        end
        ST_PROC: begin
          doneSeenN = doneSeen | procDone;
          if (clkFall) begin
            if (!lowYet) begin
              lowYetN = 1'b1;
            end else if (doneSeen || procDone) begin
              stateN  = ST_IDLE;
              lowYetN = 1'b0;
            end
          end
        end
        ST_BAD: begin
          if (clkFall) begin
            lowYetN  = 1'b1;
            fallCntN = fallCnt + FALL_W'(1);
            if (fallCnt == LAST_FALL) begin
              stateN  = ST_IDLE;
              lowYetN = 1'b0;
            end
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bytesLeft <= '0;
      fallCnt   <= '0;
      outActive <= 1'b0;
      lowYet    <= 1'b0;
      doneSeen  <= 1'b0;
      atrMode   <= 1'b0;
      cmdValid  <= 1'b0;
      frameErr  <= 1'b0;
      byteReq   <= 1'b0;
    end else begin
      state     <= stateN;
      bytesLeft <= bytesLeftN;
      fallCnt   <= fallCntN;
      outActive <= outActiveN;
      lowYet    <= lowYetN;
      doneSeen  <= doneSeenN;
      atrMode   <= atrModeN;
      cmdValid  <= cmdValidN;
      frameErr  <= frameErrN;
      byteReq   <= byteReqN;
    end
  end

  assign atrFetch = atrMode;
  assign lineOe   = ((state == ST_OUT) && outActive && !txBit) ||
                    (((state == ST_PROC) || (state == ST_BAD)) && lowYet);

  // R3: the line moves only after a falling clock edge or an abort
  assert_line_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lineOe) |-> ($past(clkFall) || $past(abortEv)));

  // R2: a command is only reported right after a stop condition
  assert_cmd_after_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(stopEv));

  // R4: a length error always leads into the fixed busy phase
  assert_bad_enters_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (state == ST_BAD));

  // R5: no frame can open while output or busy phases run
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_OUT || state == ST_PROC || state == ST_BAD) && startEv && !abortEv)
    |=> (state != ST_RX));

  // R6: the busy level holds until done has been seen
  assert_proc_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PROC) && lowYet && !doneSeen && !procDone && !abortEv) |=> lineOe);

endmodule

// File: rtl/cardLinkFront.sv
module cardLinkFront
  import cardLinkPkg::*;
#(
  parameter int CMD_BITS    = 24,
  parameter int BYTE_W      = 8,
  parameter int LEN_W       = 9,
  parameter int ATR_BYTES   = 4,
  parameter int BAD_FALLS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sysClk,
  input  logic                sysRstN,
  input  logic                cardClk,
  input  logic                cardRst,
  input  logic                lineIn,
  output logic                lineOe,
  output logic                cmdValid,
  output logic [CMD_BITS-1:0] cmdWord,
  output logic                frameErr,
  input  logic                replyOut,
  input  logic [LEN_W-1:0]    replyBytes,
  input  logic                procDone,
  output logic                byteReq,
  output logic                atrFetch,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData
);
  localparam int CNT_W = $clog2(CMD_BITS + 2);

  logic clkRise, clkFall, clkHigh, lineLevel, startEv, stopEv, rstHigh;
  logic txBit, txByteDone, bufValid;
  logic [CNT_W-1:0] rxCount;
  dpCtl_t ctl;

  linkSync #(.STAGES(SYNC_STAGES)) u_sync (
    .sysClk(sysClk), .sysRstN(sysRstN), .cardClk(cardClk), .cardRst(cardRst),
    .lineIn(lineIn), .clkRise(clkRise), .clkFall(clkFall), .clkHigh(clkHigh),
    .lineLevel(lineLevel), .startEv(startEv), .stopEv(stopEv), .rstHigh(rstHigh)
  );

  linkDatapath #(.CMD_BITS(CMD_BITS), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dp (
    .clk(sysClk), .rstN(sysRstN), .ctl(ctl), .lineLevel(lineLevel),
    .byteValid(byteValid), .byteData(byteData), .rxWord(cmdWord),
    .rxCount(rxCount), .txBit(txBit), .txByteDone(txByteDone), .bufValid(bufValid)
  );

  linkControl #(.CMD_BITS(CMD_BITS), .LEN_W(LEN_W), .CNT_W(CNT_W),
                .ATR_BYTES(ATR_BYTES), .BAD_FALLS(BAD_FALLS)) u_ctl (
    .clk(sysClk), .rstN(sysRstN), .clkRise(clkRise), .clkFall(clkFall),
    .clkHigh(clkHigh), .startEv(startEv), .stopEv(stopEv), .rstHigh(rstHigh),
    .rxCount(rxCount), .txBit(txBit), .txByteDone(txByteDone),
    .replyOut(replyOut), .replyBytes(replyBytes), .procDone(procDone),
    .ctl(ctl), .cmdValid(cmdValid), .frameErr(frameErr), .byteReq(byteReq),
    .atrFetch(atrFetch), .lineOe(lineOe)
  );

endmodule

// File: tb/cardLinkFront_tb.sv
module cardLinkFront_tb;
  localparam int HALF = 12;

  logic sysClk = 1'b0;
  logic sysRstN = 1'b0;
  logic cardClk = 1'b0;
  logic cardRst = 1'b0;
  logic ifdLine = 1'b1;
  logic replyOut = 1'b0;
  logic [8:0] replyBytes = '0;
  logic procDone = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic lineOe, cmdValid, frameErr, byteReq, atrFetch;
  logic [23:0] cmdWord;
  wire lineIn;

  assign lineIn = ifdLine & ~lineOe;

  always #4 sysClk = ~sysClk;

  cardLinkFront u_dut (
    .sysClk(sysClk), .sysRstN(sysRstN), .cardClk(cardClk), .cardRst(cardRst),
    .lineIn(lineIn), .lineOe(lineOe), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .frameErr(frameErr), .replyOut(replyOut), .replyBytes(replyBytes),
    .procDone(procDone), .byteReq(byteReq), .atrFetch(atrFetch),
    .byteValid(byteValid), .byteData(byteData)
  );

  int checks = 0;
  int fails = 0;
  int respAddr = 0;
  int reqCount = 0;
  int atrReqs = 0;
  int cmdSeen = 0;
  int errSeen = 0;
  logic [23:0] lastCmd = '0;

  function automatic logic [7:0] memAt(input int a);
    logic [31:0] t;
    t = a * 37 + 11;
    return t[7:0] ^ 8'(a >> 2);
  endfunction

  task automatic waitSys(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // byte supplier and event monitor
  initial begin
    forever begin
      @(negedge sysClk);
      byteValid = 1'b0;
      if (cmdValid) begin cmdSeen++; lastCmd = cmdWord; end
      if (frameErr) errSeen++;
      if (byteReq) begin
        reqCount++;
        if (atrFetch) atrReqs++;
        byteData = memAt(respAddr);
        respAddr++;
        byteValid = 1'b1;
      end
    end
  end

  task automatic pulse();
    cardClk = 1'b1; waitSys(HALF);
    cardClk = 1'b0; waitSys(HALF);
  endtask

  // clock pulse with a start and a stop condition inside the high phase
  task automatic glitchPulse();
    cardClk = 1'b1; waitSys(3);
    ifdLine = 1'b0; waitSys(3);
    ifdLine = 1'b1; waitSys(HALF - 6);
    cardClk = 1'b0; waitSys(HALF);
  endtask

  task automatic sendStart();
    ifdLine = 1'b1; waitSys(2);
    cardClk = 1'b1; waitSys(HALF / 2);
    ifdLine = 1'b0; waitSys(HALF / 2);
    cardClk = 1'b0; waitSys(HALF);
  endtask

  task automatic sendBit(input logic b);
    ifdLine = b; waitSys(2);
    cardClk = 1'b1; waitSys(HALF);
    cardClk = 1'b0; waitSys(HALF);
  endtask

  task automatic sendStop();
    ifdLine = 1'b0; waitSys(2);
    cardClk = 1'b1; waitSys(HALF / 2);
    ifdLine = 1'b1; waitSys(HALF / 2);
    cardClk = 1'b0; waitSys(HALF);
  endtask

  task automatic sendFrame(input int nBits, input logic [31:0] bits);
    sendStart();
    for (int i = 0; i < nBits; i++) sendBit(bits[i]);
    sendStop();
  endtask

  // first bit is expected to be on the line already
  task automatic readOut(input int nBytes, input int addr, input string req,
                         input int glitchAt);
    logic [7:0] b;
    for (int k = 0; k < nBytes * 8; k++) begin
      if (k > 0) begin
        if (k == glitchAt) glitchPulse();
        else pulse();
      end
      b = memAt(addr + k / 8);
      check((!lineOe) == b[k % 8], req, "output bit", int'(!lineOe), int'(b[k % 8]));
    end
    pulse();
    check(lineOe == 1'b0, req, "release after last bit", int'(lineOe), 0);
    pulse(); pulse();
    check(lineOe == 1'b0, req, "line stays high", int'(lineOe), 0);
  endtask

  task automatic doRead(input logic [7:0] addr, input int n, input int glitchAt);
    int c0, r0;
    logic [7:0] ctrl;
    ctrl = 8'h30;
    c0 = cmdSeen; r0 = reqCount;
    replyOut = 1'b1; replyBytes = 9'(n); respAddr = int'(addr);
    sendFrame(24, {8'h00, 8'h5A, addr, ctrl});
    check(cmdSeen == c0 + 1, "R2", "command count", cmdSeen, c0 + 1);
    check(lastCmd == {8'h5A, addr, ctrl}, "R2 R11", "command word",
          int'(lastCmd), int'({8'h5A, addr, ctrl}));
    readOut(n, int'(addr), "R7", glitchAt);
    check(reqCount == r0 + n, "R8", "byte requests", reqCount - r0, n);
  endtask

  task automatic doProc(input int pre, input bit glitch);
    int c0;
    c0 = cmdSeen;
    replyOut = 1'b0;
    sendFrame(24, {8'h00, 8'hC3, 8'h11, 8'h38});
    check(cmdSeen == c0 + 1, "R2", "command count", cmdSeen, c0 + 1);
    check(lineOe == 1'b1, "R6", "busy low after first fall", int'(lineOe), 1);
    for (int i = 0; i < pre; i++) begin
      if (glitch && i == 0) glitchPulse();
      else pulse();
      check(lineOe == 1'b1, glitch ? "R5" : "R6", "busy held", int'(lineOe), 1);
    end
    @(negedge sysClk); procDone = 1'b1;
    @(negedge sysClk); procDone = 1'b0;
    waitSys(4);
    check(lineOe == 1'b1, "R3", "no change before fall", int'(lineOe), 1);
    pulse();
    check(lineOe == 1'b0, "R6", "release after done", int'(lineOe), 0);
    pulse();
    check(lineOe == 1'b0, "R6", "stays released", int'(lineOe), 0);
  endtask

  task automatic doBad(input int nBits);
    int c0, e0;
    c0 = cmdSeen; e0 = errSeen;
    replyOut = 1'b1; replyBytes = 9'd2;
    sendFrame(nBits, $urandom());
    check(errSeen == e0 + 1, "R4", "length error flagged", errSeen, e0 + 1);
    check(cmdSeen == c0, "R4", "no command on bad length", cmdSeen, c0);
    check(lineOe == 1'b1, "R4", "busy on fall 1", int'(lineOe), 1);
    for (int f = 2; f <= 7; f++) begin
      @(negedge sysClk); procDone = (f == 3);
      pulse();
      procDone = 1'b0;
      check(lineOe == 1'b1, "R4", "busy before fall 8", int'(lineOe), 1);
    end
    pulse();
    check(lineOe == 1'b0, "R4", "release on fall 8", int'(lineOe), 0);
  endtask

  task automatic doAtr();
    int a0, r0;
    respAddr = 0; a0 = atrReqs; r0 = reqCount;
    cardRst = 1'b1; waitSys(HALF);
    check(lineOe == 1'b0, "R9", "line released in reset", int'(lineOe), 0);
    cardRst = 1'b0; waitSys(HALF);
    pulse();
    check(atrFetch == 1'b1, "R10", "answer fetch flag", int'(atrFetch), 1);
    readOut(4, 0, "R10", 9);
    check(atrReqs == a0 + 4, "R10", "answer byte requests", atrReqs - a0, 4);
    check(reqCount == r0 + 4, "R8", "total requests", reqCount - r0, 4);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge sysClk);
    fails++; checks++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : mainSeq
    int c0, e0, kind;
    void'($urandom(32'h0C0FFEE5));
    waitSys(5);
    sysRstN = 1'b1;
    waitSys(4);
    check(lineOe == 1'b0, "R3", "reset line released", int'(lineOe), 0);
    check(cmdValid == 1'b0 && frameErr == 1'b0, "R2", "no events at reset",
          int'({cmdValid, frameErr}), 0);
    check(byteReq == 1'b0, "R8", "no request at reset", int'(byteReq), 0);

    doAtr();

    // glitch in the middle of the second byte
    doRead(8'h40, 2, 11);

    // stray stop while idle
    c0 = cmdSeen; e0 = errSeen;
    sendStop();
    waitSys(4);
    check(cmdSeen == c0 && errSeen == e0 && !lineOe, "R1", "idle stop ignored",
          cmdSeen + errSeen - c0 - e0, 0);

    // restart in the middle of a frame
    replyOut = 1'b1; replyBytes = 9'd1; respAddr = 7;
    sendStart();
    for (int i = 0; i < 9; i++) sendBit(1'b1);
    c0 = cmdSeen;
    sendFrame(24, {8'h00, 8'h81, 8'h07, 8'h30});
    check(cmdSeen == c0 + 1 && lastCmd == 24'h810730, "R1", "restart word",
          int'(lastCmd), 24'h810730);
    readOut(1, 7, "R7", -1);

    doProc(3, 1'b1);

    // reset while clock high is ignored; with clock low it aborts
    replyOut = 1'b0;
    sendFrame(24, {8'h00, 8'h00, 8'h01, 8'h33});
    cardClk = 1'b1; waitSys(3);
    cardRst = 1'b1; waitSys(HALF - 6);
    cardRst = 1'b0; waitSys(3);
    cardClk = 1'b0; waitSys(HALF);
    check(lineOe == 1'b1, "R9", "reset at clock high ignored", int'(lineOe), 1);
    doAtr();

    doBad(23);
    doBad(25);
    doBad(5);

    for (int it = 0; it < 24; it++) begin
      kind = $urandom_range(0, 2);
      if (kind == 0) doRead(8'($urandom_range(0, 250)), $urandom_range(1, 3),
                            $urandom_range(1, 7));
      else if (kind == 1) doProc($urandom_range(1, 4), 1'($urandom_range(0, 1)));
      else doBad($urandom_range(0, 1) ? $urandom_range(1, 23) : $urandom_range(25, 30));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule